// File: doc/BRIEF.md
# Paravirtual Device MMIO Register Block

This block is the register file that a paravirtual device presents on a plain 32-bit memory-mapped bus. A driver uses it to identify the device and to negotiate a 64-bit feature set through 32-bit windows. It also configures a parameterised number of virtual queues, all seen through one queue-select register. The remaining registers cover device status, interrupt status with acknowledge, the discovery of shared-memory regions, and notification of new buffers.

The bus side is a single-cycle request: `req_i` with `we_i`, a 12-bit byte address and 32-bit write data. A read answers one cycle later on `rdata_o`, qualified by `rvalid_o`. The device side gets the negotiated feature word, a per-queue ready vector, a side port for reading any queue's size and ring addresses, a one-cycle notify strobe and a level interrupt.

Top module: `pv_mmio_regs`

## Requirements
- R1: Reads at 0x000, 0x004, 0x008 and 0x00c return 0x74726976, 0x2, the device-ID parameter and the vendor-ID parameter respectively.
- R2: A read of 0x010 returns device feature bits 31..0 when the word written to 0x014 is 0, bits 63..32 when it is 1, and zero for any other selector value.
- R3: A write to 0x020 stores bits 31..0 of `drv_features_o` when the selector at 0x024 holds 0 and bits 63..32 when it holds 1; with any other selector value the write is ignored.
- R4: The word at 0x030 selects a queue. A read of 0x034 returns the QMAX parameter when that index is below NUM_QUEUES and 0 otherwise.
- R5: Writes to 0x038 (size) and to the address halves take effect only on the selected existing queue. The halves are descriptor 0x080/0x084, driver area 0x090/0x094 and device area 0x0a0/0x0a4, low half first in each pair. The result is visible through the `dq_*` port for the index on `dq_idx_i`, and a non-existent index there gives zeros.
- R6: A write to 0x044 stores bit 0 as the selected queue's ready flag. Reading 0x044 returns that flag in bit 0, and `queue_ready_o[i]` mirrors the flag of queue i.
- R7: Any write to 0x050 raises `notify_valid_o` for exactly one cycle after the write, with `notify_data_o` equal to the written word.
- R8: A pulse on `used_evt_i` sets pending bit 0 and a pulse on `cfg_evt_i` sets pending bit 1. A read of 0x060 returns the pending bits, a write to 0x064 clears the bits set in the written mask, and `irq_o` is high exactly while any bit is pending.
- R9: A nonzero write to 0x070 stores its low STATUS_W bits, and a read returns them. A write of zero resets the status, the driver features, all selectors, every queue's state and all pending interrupts.
- R10: The word at 0x0ac selects a shared-memory region. Reads of 0x0b0/0x0b4 return its length (low/high) and 0x0b8/0x0bc its base, taken from the input ports. An index at or above NUM_SHM reads all ones in all four.
- R11: Writing 1 to 0x0c0 clears the selected queue's size, addresses and ready flag and makes 0x0c0 read 1 until ready is next written 1. This happens only when feature bit RING_BIT is both offered and accepted; otherwise the write is ignored.
- R12: Misaligned accesses (address bits 1..0 nonzero), accesses to unmapped offsets, reads of write-only registers and writes to read-only registers change no state and read as zero.
- R13: Every read request yields `rvalid_o` high in the next cycle and only then. Writes never produce `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| used_evt_i | input | 1 | Used-buffer event pulse |
| cfg_evt_i | input | 1 | Configuration-change event pulse |
| irq_o | output | 1 | Interrupt level |
| notify_valid_o | output | 1 | Queue notify strobe |
| notify_data_o | output | 32 | Value written with the notify |
| drv_features_o | output | 64 | Features accepted by the driver |
| queue_ready_o | output | NUM_QUEUES | Per-queue ready flags |
| dq_idx_i | input | IDX_W | Queue index for the device-side view |
| dq_size_o | output | QSZ_W | Size of queue dq_idx_i |
| dq_desc_o | output | 64 | Descriptor area address of queue dq_idx_i |
| dq_drv_o | output | 64 | Driver area address of queue dq_idx_i |
| dq_dev_o | output | 64 | Device area address of queue dq_idx_i |
| shm_len_i | input | 64*NUM_SHM | Region lengths, region i in bits 64i+63..64i |
| shm_base_i | input | 64*NUM_SHM | Region bases, same packing |

## Verification
The bench builds the block with three queues, QMAX of 64 and two shared-memory regions. With three queues the 2-bit index reaches the non-existent queue 3, so the selector paths can be checked with an out-of-range value. With two regions the unused region ID 2 becomes reachable for the all-ones readback. The device feature vector offers the ring-reset bit 40, so the queue-reset path can be exercised both with and without that bit accepted.

// File: rtl/pv_mmio_pkg.sv
package pv_mmio_pkg;
  localparam int MMIO_AW = 12;
  typedef logic [MMIO_AW-1:0] ofs_t;

  localparam logic [31:0] MAGIC_WORD  = 32'h7472_6976;
  localparam logic [31:0] VERSION_NUM = 32'h0000_0002;

  localparam ofs_t OFS_MAGIC   = 12'h000;
  localparam ofs_t OFS_VERSION = 12'h004;
  localparam ofs_t OFS_DEVID   = 12'h008;
  localparam ofs_t OFS_VENDOR  = 12'h00c;
  localparam ofs_t OFS_DFEAT   = 12'h010;
  localparam ofs_t OFS_DFSEL   = 12'h014;
  localparam ofs_t OFS_GFEAT   = 12'h020;
  localparam ofs_t OFS_GFSEL   = 12'h024;
  localparam ofs_t OFS_QSEL    = 12'h030;
  localparam ofs_t OFS_QMAX    = 12'h034;
  localparam ofs_t OFS_QSIZE   = 12'h038;
  localparam ofs_t OFS_QREADY  = 12'h044;
  localparam ofs_t OFS_NOTIFY  = 12'h050;
  localparam ofs_t OFS_ISR     = 12'h060;
  localparam ofs_t OFS_IACK    = 12'h064;
  localparam ofs_t OFS_STATUS  = 12'h070;
  localparam ofs_t OFS_DESC_LO = 12'h080;
  localparam ofs_t OFS_DESC_HI = 12'h084;
  localparam ofs_t OFS_DRV_LO  = 12'h090;
  localparam ofs_t OFS_DRV_HI  = 12'h094;
  localparam ofs_t OFS_DEV_LO  = 12'h0a0;
  localparam ofs_t OFS_DEV_HI  = 12'h0a4;
  localparam ofs_t OFS_SHMSEL  = 12'h0ac;
  localparam ofs_t OFS_SLEN_LO = 12'h0b0;
  localparam ofs_t OFS_SLEN_HI = 12'h0b4;
  localparam ofs_t OFS_SBAS_LO = 12'h0b8;
  localparam ofs_t OFS_SBAS_HI = 12'h0bc;
  localparam ofs_t OFS_QRESET  = 12'h0c0;

  localparam int N_IRQ_EV = 2;
endpackage

// File: rtl/pv_queue_bank.sv
module pv_queue_bank #(
  parameter int NQ    = 4,
  parameter int QSZ_W = 9,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             sel_ok,
  input  logic             we_size,
  input  logic             we_ready,
  input  logic             we_qrst,
  input  logic [5:0]       we_addr,
  input  logic [31:0]      wdata,
  output logic             rd_ready,
  output logic             rd_qrst,
  output logic [NQ-1:0]    ready_vec,
  input  logic [IDX_W-1:0] dq_idx,
  output logic [QSZ_W-1:0] dq_size,
  output logic [63:0]      dq_desc,
  output logic [63:0]      dq_drv,
  output logic [63:0]      dq_dev
);
  logic [QSZ_W-1:0] size_r [NQ];
  logic [63:0]      desc_r [NQ];
  logic [63:0]      drv_r  [NQ];
  logic [63:0]      dev_r  [NQ];
  logic [NQ-1:0]    ready_r;
  logic [NQ-1:0]    qrst_r;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic hit;
    assign hit = sel_ok && (sel_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst || clr_all || (hit && we_qrst && wdata[0])) begin
        size_r[g]  <= '0;
        desc_r[g]  <= '0;
        drv_r[g]   <= '0;
        dev_r[g]   <= '0;
        ready_r[g] <= 1'b0;
        qrst_r[g]  <= !(rst || clr_all);
      end else if (hit) begin
        if (we_size) size_r[g] <= wdata[QSZ_W-1:0];
        if (we_ready) begin
          ready_r[g] <= wdata[0];
          if (wdata[0]) qrst_r[g] <= 1'b0;
        end
        if (we_addr[0]) desc_r[g][31:0]  <= wdata;
        if (we_addr[1]) desc_r[g][63:32] <= wdata;
        if (we_addr[2]) drv_r[g][31:0]   <= wdata;
        if (we_addr[3]) drv_r[g][63:32]  <= wdata;
        if (we_addr[4]) dev_r[g][31:0]   <= wdata;
        if (we_addr[5]) dev_r[g][63:32]  <= wdata;
      end
    end
  end

  assign ready_vec = ready_r;

  always_comb begin
    rd_ready = 1'b0;
    rd_qrst  = 1'b0;
    dq_size  = '0;
    dq_desc  = '0;
    dq_drv   = '0;
    dq_dev   = '0;
    for (int i = 0; i < NQ; i++) begin
      if (sel_ok && sel_idx == IDX_W'(i)) begin
        rd_ready = ready_r[i];
        rd_qrst  = qrst_r[i];
      end
      if (dq_idx == IDX_W'(i)) begin
        dq_size = size_r[i];
        dq_desc = desc_r[i];
        dq_drv  = drv_r[i];
        dq_dev  = dev_r[i];
      end
    end
  end
endmodule

// File: rtl/pv_irq_status.sv
module pv_irq_status #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_all,
  input  logic [NEV-1:0] evt,
  input  logic           ack_we,
  input  logic [NEV-1:0] ack_mask,
  output logic [NEV-1:0] pending_o,
  output logic           irq_o
);
  logic [NEV-1:0] pend_r, pend_nxt;

  always_comb begin
    pend_nxt = pend_r;
    if (ack_we) pend_nxt = pend_nxt & ~ack_mask;
    pend_nxt = pend_nxt | evt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      pend_r <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_r <= pend_nxt;
      irq_o  <= |pend_nxt;
    end
  end

  assign pending_o = pend_r;
endmodule

// File: rtl/pv_mmio_regs.sv
module pv_mmio_regs
  import pv_mmio_pkg::*;
#(
  parameter int          NUM_QUEUES   = 4,
  parameter int          QMAX         = 256,
  parameter int          NUM_SHM      = 2,
  parameter int          STATUS_W     = 8,
  parameter int          RING_BIT     = 40,
  parameter logic [63:0] DEV_FEATURES = 64'h0000_0130_8000_00A5,
  parameter logic [31:0] DEVICE_ID    = 32'h0000_0001,
  parameter logic [31:0] VENDOR_ID    = 32'h0000_5EED,
  localparam int         IDX_W        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int         QSZ_W        = $clog2(QMAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [MMIO_AW-1:0]      addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    rvalid_o,
  input  logic                    used_evt_i,
  input  logic                    cfg_evt_i,
  output logic                    irq_o,
  output logic                    notify_valid_o,
  output logic [31:0]             notify_data_o,
  output logic [63:0]             drv_features_o,
  output logic [NUM_QUEUES-1:0]   queue_ready_o,
  input  logic [IDX_W-1:0]        dq_idx_i,
  output logic [QSZ_W-1:0]        dq_size_o,
  output logic [63:0]             dq_desc_o,
  output logic [63:0]             dq_drv_o,
  output logic [63:0]             dq_dev_o,
  input  logic [64*NUM_SHM-1:0]   shm_len_i,
  input  logic [64*NUM_SHM-1:0]   shm_base_i
);
  logic aligned, wr, rd, dev_rst;
  logic [31:0] dfsel_r, gfsel_r, qsel_r, shmsel_r;
  logic [STATUS_W-1:0] status_r;
  logic [63:0] gfeat_r;
  logic q_ok, ring_ok, rd_ready, rd_qrst;
  logic [N_IRQ_EV-1:0] pend;
  logic [63:0] shm_len, shm_base;
  logic [31:0] rd_val;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i && aligned;
  assign dev_rst = wr && (addr_i == OFS_STATUS) && (wdata_i == 32'd0);
  assign q_ok    = (qsel_r < 32'(NUM_QUEUES));
  assign ring_ok = gfeat_r[RING_BIT] && DEV_FEATURES[RING_BIT];

  always_ff @(posedge clk) begin
    if (rst || dev_rst) begin
      dfsel_r  <= '0;
      gfsel_r  <= '0;
      qsel_r   <= '0;
      shmsel_r <= '0;
      gfeat_r  <= '0;
      status_r <= '0;
    end else if (wr) begin
      case (addr_i)
        OFS_DFSEL:  dfsel_r  <= wdata_i;
        OFS_GFSEL:  gfsel_r  <= wdata_i;
        OFS_QSEL:   qsel_r   <= wdata_i;
        OFS_SHMSEL: shmsel_r <= wdata_i;
        OFS_STATUS: status_r <= wdata_i[STATUS_W-1:0];
        OFS_GFEAT: begin
          if (gfsel_r == 32'd0) gfeat_r[31:0]  <= wdata_i;
          if (gfsel_r == 32'd1) gfeat_r[63:32] <= wdata_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      notify_valid_o <= 1'b0;
      notify_data_o  <= '0;
    end else begin
      notify_valid_o <= wr && (addr_i == OFS_NOTIFY);
      notify_data_o  <= wdata_i;
    end
  end

  pv_queue_bank #(.NQ(NUM_QUEUES), .QSZ_W(QSZ_W), .IDX_W(IDX_W)) u_qbank (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (dev_rst),
    .sel_idx  (qsel_r[IDX_W-1:0]),
    .sel_ok   (q_ok),
    .we_size  (wr && addr_i == OFS_QSIZE),
    .we_ready (wr && addr_i == OFS_QREADY),
    .we_qrst  (wr && addr_i == OFS_QRESET && ring_ok),
    .we_addr  ({wr && addr_i == OFS_DEV_HI, wr && addr_i == OFS_DEV_LO,
                wr && addr_i == OFS_DRV_HI, wr && addr_i == OFS_DRV_LO,
                wr && addr_i == OFS_DESC_HI, wr && addr_i == OFS_DESC_LO}),
    .wdata    (wdata_i),
    .rd_ready (rd_ready),
    .rd_qrst  (rd_qrst),
    .ready_vec(queue_ready_o),
    .dq_idx   (dq_idx_i),
    .dq_size  (dq_size_o),
    .dq_desc  (dq_desc_o),
    .dq_drv   (dq_drv_o),
    .dq_dev   (dq_dev_o)
  );

  pv_irq_status #(.NEV(N_IRQ_EV)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (dev_rst),
    .evt      ({cfg_evt_i, used_evt_i}),
    .ack_we   (wr && addr_i == OFS_IACK),
    .ack_mask (wdata_i[N_IRQ_EV-1:0]),
    .pending_o(pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    shm_len  = '1;
    shm_base = '1;
    for (int i = 0; i < NUM_SHM; i++) begin
      if (shmsel_r == 32'(i)) begin
        shm_len  = shm_len_i[64*i +: 64];
        shm_base = shm_base_i[64*i +: 64];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      OFS_MAGIC:   rd_val = MAGIC_WORD;
      OFS_VERSION: rd_val = VERSION_NUM;
      OFS_DEVID:   rd_val = DEVICE_ID;
      OFS_VENDOR:  rd_val = VENDOR_ID;
      OFS_DFEAT:   rd_val = (dfsel_r == 32'd0) ? DEV_FEATURES[31:0] :
                            (dfsel_r == 32'd1) ? DEV_FEATURES[63:32] : 32'd0;
      OFS_QMAX:    rd_val = q_ok ? 32'(QMAX) : 32'd0;
      OFS_QREADY:  rd_val = {31'd0, rd_ready};
      OFS_QRESET:  rd_val = {31'd0, rd_qrst};
      OFS_ISR:     rd_val = 32'(pend);
      OFS_STATUS:  rd_val = 32'(status_r);
      OFS_SLEN_LO: rd_val = shm_len[31:0];
      OFS_SLEN_HI: rd_val = shm_len[63:32];
      OFS_SBAS_LO: rd_val = shm_base[31:0];
      OFS_SBAS_HI: rd_val = shm_base[63:32];
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      rdata_o  <= rd ? rd_val : 32'd0;
    end
  end

  assign drv_features_o = gfeat_r;
endmodule

// File: rtl/pv_mmio_regs_chk.sv
module pv_mmio_regs_chk
  import pv_mmio_pkg::*;
#(
  parameter int NQ = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_i,
  input logic               we_i,
  input logic [MMIO_AW-1:0] addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic               rvalid_o,
  input logic               used_evt_i,
  input logic               cfg_evt_i,
  input logic               irq_o,
  input logic               notify_valid_o,
  input logic [31:0]        notify_data_o,
  input logic [63:0]        drv_features_o,
  input logic [NQ-1:0]      queue_ready_o
);
  logic zero_stat_wr;
  assign zero_stat_wr = req_i && we_i && (addr_i == OFS_STATUS) && (wdata_i == 32'd0);

  // R13
  rd_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && !we_i) |=> rvalid_o);

  // R13
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_i && !we_i) |=> !rvalid_o);

  // R1
  magic_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && !we_i && addr_i == OFS_MAGIC) |=> (rdata_o == MAGIC_WORD));

  // R7
  notify_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && we_i && addr_i == OFS_NOTIFY) |=>
      (notify_valid_o && notify_data_o == $past(wdata_i)));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((used_evt_i || cfg_evt_i) && !zero_stat_wr) |=> irq_o);

  // R9
  dev_reset_chk: assert property (@(posedge clk) disable iff (rst)
    zero_stat_wr |=> (drv_features_o == 64'd0 && queue_ready_o == '0 && !irq_o));

  // R12
  misalign_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && !we_i && addr_i[1:0] != 2'b00) |=> (rdata_o == 32'd0));
endmodule

bind pv_mmio_regs pv_mmio_regs_chk #(.NQ(NUM_QUEUES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_i          (req_i),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .rdata_o        (rdata_o),
  .rvalid_o       (rvalid_o),
  .used_evt_i     (used_evt_i),
  .cfg_evt_i      (cfg_evt_i),
  .irq_o          (irq_o),
  .notify_valid_o (notify_valid_o),
  .notify_data_o  (notify_data_o),
  .drv_features_o (drv_features_o),
  .queue_ready_o  (queue_ready_o)
);

// File: tb/test_pv_mmio_regs.sv
module test_pv_mmio_regs;
  localparam int          NQ    = 3;
  localparam int          QMAX  = 64;
  localparam int          NSHM  = 2;
  localparam logic [63:0] FEATS = 64'h0000_0130_8000_00A5;
  localparam logic [31:0] DEVID = 32'h0000_001A;
  localparam logic [31:0] VENID = 32'h0000_5EED;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic rvalid_o;
  logic used_evt_i = 1'b0, cfg_evt_i = 1'b0;
  logic irq_o, notify_valid_o;
  logic [31:0] notify_data_o;
  logic [63:0] drv_features_o;
  logic [NQ-1:0] queue_ready_o;
  logic [1:0] dq_idx_i = '0;
  logic [6:0] dq_size_o;
  logic [63:0] dq_desc_o, dq_drv_o, dq_dev_o;
  logic [127:0] shm_len_i  = {64'h0000_0000_0000_0400, 64'h0000_0001_0000_2000};
  logic [127:0] shm_base_i = {64'h0000_0000_0000_1234, 64'h8000_0000_4000_0000};

  always #4 clk = ~clk;

  pv_mmio_regs #(.NUM_QUEUES(NQ), .QMAX(QMAX), .NUM_SHM(NSHM), .DEV_FEATURES(FEATS),
                 .DEVICE_ID(DEVID), .VENDOR_ID(VENID)) i_pv_mmio_regs (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .used_evt_i(used_evt_i), .cfg_evt_i(cfg_evt_i),
    .irq_o(irq_o), .notify_valid_o(notify_valid_o), .notify_data_o(notify_data_o),
    .drv_features_o(drv_features_o), .queue_ready_o(queue_ready_o), .dq_idx_i(dq_idx_i),
    .dq_size_o(dq_size_o), .dq_desc_o(dq_desc_o), .dq_drv_o(dq_drv_o), .dq_dev_o(dq_dev_o),
    .shm_len_i(shm_len_i), .shm_base_i(shm_base_i));

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    exp_q.push_back('{e, tag});
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic pulse(input bit cfg);
    @(negedge clk);
    if (cfg) cfg_evt_i = 1'b1; else used_evt_i = 1'b1;
    @(negedge clk);
    cfg_evt_i = 1'b0; used_evt_i = 1'b0;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rvalid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R13 unexpected rvalid", {32'd0, rdata_o}, 64'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rdata_o == e.val, e.tag, {32'd0, rdata_o}, {32'd0, e.val});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(irq_o == 0 && queue_ready_o == 0 && drv_features_o == 0 && rvalid_o == 0,
          "R9 reset state", {irq_o, queue_ready_o, rvalid_o}, 64'd0);

    // R1 identification
    rd(12'h000, 32'h7472_6976, "R1 magic");
    rd(12'h004, 32'h2, "R1 version");
    rd(12'h008, DEVID, "R1 device id");
    rd(12'h00c, VENID, "R1 vendor id");

    // R2 device feature window
    wr(12'h014, 1); rd(12'h010, FEATS[63:32], "R2 feature hi");
    wr(12'h014, 0); rd(12'h010, FEATS[31:0], "R2 feature lo");
    wr(12'h014, 2); rd(12'h010, 32'd0, "R2 feature sel 2");

    // R3 driver features
    wr(12'h024, 1); wr(12'h020, 32'h0000_0100);
    wr(12'h024, 0); wr(12'h020, 32'hDEAD_0001);
    wr(12'h024, 5); wr(12'h020, 32'hFFFF_FFFF);
    check(drv_features_o == 64'h0000_0100_DEAD_0001, "R3 driver features",
          drv_features_o, 64'h0000_0100_DEAD_0001);

    // R4 queue max
    wr(12'h030, 2); rd(12'h034, QMAX, "R4 max valid queue");
    wr(12'h030, 3); rd(12'h034, 32'd0, "R4 max missing queue");

    // R5 writes to a missing queue are dropped
    wr(12'h038, 7); wr(12'h044, 1); wr(12'h080, 32'h55);
    check(queue_ready_o == 0, "R5 missing queue ready", queue_ready_o, 0);
    dq_idx_i = 2'd3; #1;
    check(dq_size_o == 0 && dq_desc_o == 0, "R5 missing dq port", dq_size_o, 0);

    // R5 per-queue configuration
    wr(12'h030, 1);
    wr(12'h038, 32); wr(12'h080, 32'h1000); wr(12'h084, 32'h2);
    wr(12'h090, 32'h3000); wr(12'h094, 32'h4); wr(12'h0a0, 32'h5000); wr(12'h0a4, 32'h6);
    dq_idx_i = 2'd1; #1;
    check(dq_size_o == 32, "R5 size", dq_size_o, 32);
    check(dq_desc_o == 64'h2_0000_1000 && dq_drv_o == 64'h4_0000_3000 && dq_dev_o == 64'h6_0000_5000,
          "R5 addresses", dq_desc_o, 64'h2_0000_1000);
    dq_idx_i = 2'd0; #1;
    check(dq_size_o == 0 && dq_desc_o == 0, "R5 other queue untouched", dq_size_o, 0);

    // R6 ready
    wr(12'h044, 1); rd(12'h044, 1, "R6 ready readback");
    check(queue_ready_o == 3'b010, "R6 ready vector", queue_ready_o, 3'b010);
    wr(12'h030, 0); rd(12'h044, 0, "R6 other queue ready");

    // R11 queue reset with ring reset accepted
    wr(12'h030, 1); wr(12'h0c0, 1);
    rd(12'h0c0, 1, "R11 reset flag");
    dq_idx_i = 2'd1; #1;
    check(queue_ready_o == 0 && dq_size_o == 0 && dq_desc_o == 0, "R11 queue cleared",
          {queue_ready_o, dq_size_o}, 0);
    // R11 without ring reset accepted: ignored
    wr(12'h024, 1); wr(12'h020, 0);
    wr(12'h038, 5); wr(12'h044, 1);
    rd(12'h0c0, 0, "R11 flag cleared by ready");
    wr(12'h0c0, 1);
    #1;
    check(queue_ready_o == 3'b010 && dq_size_o == 5, "R11 reset ignored",
          {queue_ready_o, dq_size_o}, {3'b010, 7'd5});

    // R7 notify
    wr(12'h050, 32'h2);
    check(notify_valid_o && notify_data_o == 32'h2, "R7 notify strobe", notify_data_o, 32'h2);
    @(negedge clk);
    check(!notify_valid_o, "R7 notify one cycle", notify_valid_o, 0);

    // R8 interrupts
    pulse(0);
    check(irq_o, "R8 irq used", irq_o, 1);
    rd(12'h060, 1, "R8 status used");
    pulse(1);
    rd(12'h060, 3, "R8 status both");
    wr(12'h064, 1); rd(12'h060, 2, "R8 ack bit0");
    check(irq_o, "R8 irq still", irq_o, 1);
    wr(12'h064, 2);
    check(!irq_o, "R8 irq cleared", irq_o, 0);
    rd(12'h060, 0, "R8 status clear");

    // R10 shared memory
    wr(12'h0ac, 0);
    rd(12'h0b0, 32'h0000_2000, "R10 len lo");
    rd(12'h0b4, 32'h0000_0001, "R10 len hi");
    rd(12'h0b8, 32'h4000_0000, "R10 base lo");
    rd(12'h0bc, 32'h8000_0000, "R10 base hi");
    wr(12'h0ac, 1); rd(12'h0b0, 32'h400, "R10 region1 len");
    wr(12'h0ac, 2);
    rd(12'h0b0, 32'hFFFF_FFFF, "R10 unused len lo");
    rd(12'h0b4, 32'hFFFF_FFFF, "R10 unused len hi");
    rd(12'h0b8, 32'hFFFF_FFFF, "R10 unused base lo");
    rd(12'h0bc, 32'hFFFF_FFFF, "R10 unused base hi");

    // R12 ignored accesses
    rd(12'h001, 32'd0, "R12 misaligned read");
    rd(12'h038, 32'd0, "R12 write-only read");
    rd(12'h0fc, 32'd0, "R12 unmapped read");
    wr(12'h000, 32'h1234); rd(12'h000, 32'h7472_6976, "R12 read-only write");
    wr(12'h070, 32'h0F); wr(12'h071, 32'h05);
    rd(12'h070, 32'h0F, "R9 status / R12 misaligned write");

    // R9 device reset
    wr(12'h030, 3);
    pulse(0);
    wr(12'h070, 0);
    check(!irq_o && queue_ready_o == 0 && drv_features_o == 0, "R9 reset outputs",
          {irq_o, queue_ready_o}, 0);
    rd(12'h070, 0, "R9 status zero");
    rd(12'h034, QMAX, "R9 queue select cleared");
    rd(12'h060, 0, "R9 pending cleared");
    dq_idx_i = 2'd1; #1;
    check(dq_size_o == 0 && dq_drv_o == 0, "R9 queue state cleared", dq_size_o, 0);

    // R13 writes make no rvalid; all reads answered
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R13 reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule